// File: doc/BRIEF.md
# Halt-Protected SPI Master Transmit Path

This block is a small SPI master that sends and receives one byte at a time. Software puts a byte into a one-entry transmit buffer over a simple register bus. A state machine moves the byte into a shift register and clocks it out most significant bit first in mode 0, with the serial clock at one quarter of the system clock. At the same time it captures the byte that comes back on the data-in pin. Two status flags report the block's state. The transmit-empty flag shows that the buffer can take another byte. The receive-full flag shows that a received byte is waiting. The receive-full flag is cleared in two steps: read the status register while the flag is set, then read the data register.

The controller can be stopped in a debug halt. A debugger may then read registers without changing the state of the block. While the halt input is high and the clear-enable input is low, bus accesses have no side effects. A data write is dropped. A status read does not arm the two-step clear, and a data read does not clear anything. A two-step clear that was armed before the halt stays armed through it, so a data read after the halt completes it. With clear-enable high, accesses during the halt act as they do outside it, and any flag they clear stays cleared once the halt ends. Flag changes made by the hardware itself (a byte leaving the buffer, a byte arriving) are never held back.

The shifter state machine has three states: `ST_IDLE`, `ST_SHIFT` and `ST_DONE`. Its transitions are:
- `ST_IDLE` to `ST_SHIFT` (`take`): a byte is waiting in the buffer.
- `ST_SHIFT` to `ST_SHIFT`: any clock phase other than the last phase of the last bit.
- `ST_SHIFT` to `ST_DONE` (`last`): the last phase of bit 7.
- `ST_DONE` to `ST_IDLE`: always, after one cycle.

Top module: `spi_halt_guard`

## Requirements
- R1: After reset the status register (address 0) reads 0x02. Bit 1 is transmit-empty and is 1. Bit 7 is receive-full and is 0. Bit 0 is busy and is 0. SS is high and SCK is low.
- R2: A write to the data register (address 1) outside the halt clears transmit-empty and queues the byte. The byte then moves into the shift register, which sets transmit-empty again and starts exactly one transfer.
- R3: Each byte goes out MSB first in mode 0. SCK idles low and gives 8 rising edges per byte. Each SCK period is 4 system clocks. SS is low for the whole byte, and SCK is never high while SS is high.
- R4: MISO is sampled on each rising edge of SCK. After 8 bits the received byte is readable at address 1 and receive-full is set. With MOSI looped back to MISO, the byte read back equals the byte sent.
- R5: Receive-full is cleared only by a status read made while it is set, followed by a data read. A data read without that earlier status read leaves the flag set.
- R6: While halt is high and clear-enable is low, a data write is ignored. It starts no transfer, not even after the halt ends, and transmit-empty stays 1.
- R7: While halt is high and clear-enable is low, reads neither arm nor clear receive-full. A status read armed before the halt is kept, and the first data read after the halt clears the flag.
- R8: While halt is high and clear-enable is high, data writes start transfers and the two-step clear works. A flag cleared in this way stays cleared after the halt ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| halt_i | input | 1 | Debug halt active |
| clr_en_i | input | 1 | Allow accesses during halt to have side effects |
| bus_addr | input | 1 | Register select: 0 = status, 1 = data |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational) |
| miso_i | input | 1 | Serial data in |
| mosi_o | output | 1 | Serial data out |
| sck_o | output | 1 | Serial clock |
| ss_n_o | output | 1 | Slave select, active low |

## Verification
The hardest case to reach is an armed two-step clear that carries across a halt. The status read must land while receive-full is set and before the halt begins. The flag must then survive protected reads inside the halt and clear on the first data read afterwards. The bench waits a fixed number of cycles for each transfer instead of polling the status register, so that no read arms the clear by accident. It then orders the status read, the halt edges and the data reads by hand. It repeats the same sequence with clear-enable high, and with the arming read placed only inside the halt, to show that such a read does not arm. All 256 byte values are sent in loopback before these cases run.

// File: rtl/spi_hg_pkg.sv
package spi_hg_pkg;
    localparam int DATA_W = 8;

    localparam logic ADDR_STAT = 1'b0;
    localparam logic ADDR_DATA = 1'b1;

    localparam int STAT_BUSY_BIT  = 0;
    localparam int STAT_TXE_BIT   = 1;
    localparam int STAT_RXF_BIT   = 7;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } shift_state_t;
endpackage

// File: rtl/spi_hg_regs.sv
module spi_hg_regs
    import spi_hg_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         halt_i,
    input  logic         clr_en_i,
    input  logic         bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         take_i,
    input  logic         rx_done_i,
    input  logic [W-1:0] rx_byte_i,
    input  logic         busy_i,
    output logic [W-1:0] tx_buf_o,
    output logic         tx_empty_o,
    output logic         rx_full_o
);
    logic         access_ok;
    logic         wr_data_ok;
    logic         rd_stat_ok;
    logic         rd_data_ok;
    logic         rx_armed;
    logic [W-1:0] rx_buf;
    logic [W-1:0] status;

    assign access_ok  = !halt_i || clr_en_i;
    assign wr_data_ok = bus_wr && (bus_addr == ADDR_DATA) && access_ok;
    assign rd_stat_ok = bus_rd && (bus_addr == ADDR_STAT) && access_ok;
    assign rd_data_ok = bus_rd && (bus_addr == ADDR_DATA) && access_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_buf_o   <= '0;
            tx_empty_o <= 1'b1;
        end else if (wr_data_ok) begin
            tx_buf_o   <= bus_wdata;
            tx_empty_o <= 1'b0;
        end else if (take_i) begin
            tx_empty_o <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_buf    <= '0;
            rx_full_o <= 1'b0;
            rx_armed  <= 1'b0;
        end else if (rx_done_i) begin
            rx_buf    <= rx_byte_i;
            rx_full_o <= 1'b1;
        end else if (rd_data_ok && rx_armed) begin
            rx_full_o <= 1'b0;
            rx_armed  <= 1'b0;
        end else if (rd_stat_ok && rx_full_o) begin
            rx_armed  <= 1'b1;
        end
    end

    always_comb begin
        status                = '0;
        status[STAT_BUSY_BIT] = busy_i;
        status[STAT_TXE_BIT]  = tx_empty_o;
        status[STAT_RXF_BIT]  = rx_full_o;
    end

    assign bus_rdata = (bus_addr == ADDR_DATA) ? rx_buf : status;
endmodule

// File: rtl/spi_hg_shifter.sv
module spi_hg_shifter
    import spi_hg_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pending_i,
    input  logic [W-1:0] tx_buf_i,
    input  logic         miso_i,
    output logic         take_o,
    output logic         rx_done_o,
    output logic [W-1:0] rx_byte_o,
    output logic         busy_o,
    output logic         mosi_o,
    output logic         sck_o,
    output logic         ss_n_o
);
    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam int BC_W = (W > 2) ? $clog2(W) : 1;
    localparam int HALF = DIV / 2;

    shift_state_t state, state_nx;
    logic [PH_W-1:0] phase;
    logic [BC_W-1:0] bit_cnt;
    logic [W-1:0]    tx_sr;
    logic [W-1:0]    rx_sr;
    logic            ph_sample;
    logic            ph_last;
    logic            last;

    assign ph_sample = (phase == PH_W'(HALF - 1));
    assign ph_last   = (phase == PH_W'(DIV - 1));
    assign last      = ph_last && (bit_cnt == BC_W'(W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (pending_i) state_nx = ST_SHIFT;
            ST_SHIFT: if (last)      state_nx = ST_DONE;
            ST_DONE:                 state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= '0;
            bit_cnt <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    phase   <= '0;
                    bit_cnt <= '0;
                    if (pending_i) tx_sr <= tx_buf_i;
                end
                ST_SHIFT: begin
                    phase <= ph_last ? '0 : phase + 1'b1;
                    if (ph_sample) rx_sr <= {rx_sr[W-2:0], miso_i};
                    if (ph_last) begin
                        tx_sr   <= {tx_sr[W-2:0], 1'b0};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                ST_DONE: begin
                    phase <= '0;
                end
                default: begin
                    phase <= '0;
                end
            endcase
        end
    end

    always_comb begin
        take_o    = 1'b0;
        rx_done_o = 1'b0;
        busy_o    = 1'b1;
        ss_n_o    = 1'b1;
        sck_o     = 1'b0;
        mosi_o    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                busy_o = 1'b0;
                take_o = pending_i;
            end
            ST_SHIFT: begin
                ss_n_o = 1'b0;
                sck_o  = (phase >= PH_W'(HALF));
                mosi_o = tx_sr[W-1];
            end
            ST_DONE: begin
                rx_done_o = 1'b1;
            end
            default: begin
                busy_o = 1'b0;
            end
        endcase
    end

    assign rx_byte_o = rx_sr;
endmodule

// File: rtl/spi_halt_guard.sv
module spi_halt_guard
    import spi_hg_pkg::*;
#(
    parameter int W   = DATA_W,
    parameter int DIV = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         halt_i,
    input  logic         clr_en_i,
    input  logic         bus_addr,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [W-1:0] bus_wdata,
    output logic [W-1:0] bus_rdata,
    input  logic         miso_i,
    output logic         mosi_o,
    output logic         sck_o,
    output logic         ss_n_o
);
    logic         take;
    logic         rx_done;
    logic [W-1:0] rx_byte;
    logic         busy;
    logic [W-1:0] tx_buf;
    logic         tx_empty;
    logic         rx_full;

    spi_hg_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_i     (halt_i),
        .clr_en_i   (clr_en_i),
        .bus_addr   (bus_addr),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .take_i     (take),
        .rx_done_i  (rx_done),
        .rx_byte_i  (rx_byte),
        .busy_i     (busy),
        .tx_buf_o   (tx_buf),
        .tx_empty_o (tx_empty),
        .rx_full_o  (rx_full)
    );

    spi_hg_shifter #(.W(W), .DIV(DIV)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending_i (!tx_empty),
        .tx_buf_i  (tx_buf),
        .miso_i    (miso_i),
        .take_o    (take),
        .rx_done_o (rx_done),
        .rx_byte_o (rx_byte),
        .busy_o    (busy),
        .mosi_o    (mosi_o),
        .sck_o     (sck_o),
        .ss_n_o    (ss_n_o)
    );
endmodule

// File: rtl/spi_halt_guard_chk.sv
module spi_halt_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_i,
    input logic clr_en_i,
    input logic bus_addr,
    input logic bus_wr,
    input logic tx_empty,
    input logic rx_full,
    input logic sck_o,
    input logic ss_n_o,
    input logic mosi_o
);
    a_r3_sck_only_when_selected: assert property (@(posedge clk) disable iff (!rst_n)
        ss_n_o |-> !sck_o);

    a_r3_mosi_stable_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sck_o) |=> $stable(mosi_o));

    a_r2_write_queues_byte: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && (!halt_i || clr_en_i)) |=> !tx_empty);

    a_r6_write_ignored_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !clr_en_i && bus_wr && bus_addr && tx_empty) |=> tx_empty);

    a_r7_rxfull_held_in_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !clr_en_i && rx_full) |=> rx_full);
endmodule

bind spi_halt_guard spi_halt_guard_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .halt_i   (halt_i),
    .clr_en_i (clr_en_i),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .tx_empty (tx_empty),
    .rx_full  (rx_full),
    .sck_o    (sck_o),
    .ss_n_o   (ss_n_o),
    .mosi_o   (mosi_o)
);

// File: tb/spi_halt_guard_test.sv
`timescale 1ns/1ps
module spi_halt_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_i = 1'b0;
    logic       clr_en_i = 1'b0;
    logic       bus_addr = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       mosi_o, sck_o, ss_n_o;

    int n_tests = 0;
    int n_fail  = 0;
    int ss_falls = 0;
    int sck_rises = 0;
    logic [7:0] cap = 8'h00;
    bit finished = 0;

    always #5 clk = ~clk;

    spi_halt_guard uut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .clr_en_i(clr_en_i),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .miso_i(mosi_o), .mosi_o(mosi_o), .sck_o(sck_o), .ss_n_o(ss_n_o)
    );

    always @(negedge ss_n_o) if (rst_n) ss_falls++;
    always @(posedge sck_o) begin
        sck_rises++;
        cap = {cap[6:0], mosi_o};
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] v);
        @(negedge clk);
        bus_addr = 1'b1; bus_wdata = v; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int f0, r0;
        idle(3);
        // R1 reset state
        check(ss_n_o == 1'b1, "R1 ss_n", ss_n_o, 1);
        check(sck_o == 1'b0, "R1 sck", sck_o, 0);
        rst_n = 1'b1;
        idle(2);
        bus_read(1'b0, d);
        check(d == 8'h02, "R1 status", d, 8'h02);

        // R2 R3 R4 R5: loopback sweep over every byte value
        for (int v = 0; v < 256; v++) begin
            f0 = ss_falls; r0 = sck_rises;
            bus_write(v[7:0]);
            idle(50);
            check(ss_falls - f0 == 1, "R2 one transfer", ss_falls - f0, 1);
            check(sck_rises - r0 == 8, "R3 sck edges", sck_rises - r0, 8);
            check(cap == v[7:0], "R3 msb first", cap, v);
            if (v == 8'hA5) begin
                bus_read(1'b1, d);
                check(d == v[7:0], "R4 data", d, v);
                bus_read(1'b0, d);
                check(d == 8'h82, "R5 unarmed read keeps flag", d, 8'h82);
            end else begin
                bus_read(1'b0, d);
                check(d == 8'h82, "R4 status full", d, 8'h82);
            end
            bus_read(1'b1, d);
            check(d == v[7:0], "R4 loopback", d, v);
            bus_read(1'b0, d);
            check(d == 8'h02, "R5 cleared", d, 8'h02);
        end

        // R3 SCK period of 4 system clocks
        bus_write(8'h3C);
        @(posedge sck_o); r0 = 0;
        @(negedge clk);
        while (sck_o) begin r0++; @(negedge clk); end
        while (!sck_o) begin r0++; @(negedge clk); end
        check(r0 == 4, "R3 period", r0, 4);
        idle(50);
        bus_read(1'b0, d); bus_read(1'b1, d);
        check(d == 8'h3C, "R4 data 3C", d, 8'h3C);

        // R6 protected write during halt
        halt_i = 1'b1; clr_en_i = 1'b0;
        f0 = ss_falls;
        bus_write(8'h77);
        idle(50);
        check(ss_falls == f0, "R6 no transfer in halt", ss_falls - f0, 0);
        bus_read(1'b0, d);
        check(d == 8'h02, "R6 status in halt", d, 8'h02);
        halt_i = 1'b0;
        idle(50);
        check(ss_falls == f0, "R6 no transfer after halt", ss_falls - f0, 0);
        bus_read(1'b1, d);
        check(d == 8'h3C, "R6 rx buffer untouched", d, 8'h3C);

        // R7 armed before halt, completed after
        bus_write(8'h5A);
        idle(50);
        bus_read(1'b0, d);
        check(d == 8'h82, "R7 full before halt", d, 8'h82);
        halt_i = 1'b1;
        bus_read(1'b0, d);
        bus_read(1'b1, d);
        bus_read(1'b1, d);
        bus_read(1'b0, d);
        check(d == 8'h82, "R7 held in halt", d, 8'h82);
        halt_i = 1'b0;
        bus_read(1'b1, d);
        check(d == 8'h5A, "R7 data", d, 8'h5A);
        bus_read(1'b0, d);
        check(d == 8'h02, "R7 cleared after halt", d, 8'h02);

        // R7 a status read inside a protected halt does not arm
        bus_write(8'hC3);
        idle(50);
        halt_i = 1'b1;
        bus_read(1'b0, d);
        halt_i = 1'b0;
        bus_read(1'b1, d);
        bus_read(1'b0, d);
        check(d == 8'h82, "R7 halt read did not arm", d, 8'h82);
        bus_read(1'b1, d);
        bus_read(1'b0, d);
        check(d == 8'h02, "R7 normal clear", d, 8'h02);

        // R8 clear-enable set during halt
        halt_i = 1'b1; clr_en_i = 1'b1;
        f0 = ss_falls;
        bus_write(8'h96);
        idle(50);
        check(ss_falls - f0 == 1, "R8 write starts transfer", ss_falls - f0, 1);
        bus_read(1'b0, d);
        check(d == 8'h82, "R8 full in halt", d, 8'h82);
        bus_read(1'b1, d);
        check(d == 8'h96, "R8 data", d, 8'h96);
        bus_read(1'b0, d);
        check(d == 8'h02, "R8 cleared in halt", d, 8'h02);
        halt_i = 1'b0; clr_en_i = 1'b0;
        idle(10);
        bus_read(1'b0, d);
        check(d == 8'h02, "R8 stays cleared", d, 8'h02);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule